// File: doc/BRIEF.md
# Prioritized Local Interrupt Acceptance Unit

This unit sits in front of a single processor core and collects interrupt messages. Each message names an 8-bit vector and a trigger mode, either level or edge. The unit latches the message into a per-vector pending bit and records its trigger mode. It does this whether or not the core currently has interrupts enabled, so no message is lost while the core runs with interrupts masked.

A vector's priority class is its upper four bits. A pending vector becomes deliverable only when its class is strictly greater than two values: the class held in a writable task-priority register, and the class of the highest vector currently in service. While any vector is deliverable and the core's interrupt-enable input is high, a single request line goes high.

When the core acknowledges, the unit returns the highest-numbered deliverable vector and moves that vector from pending to in service. An end-of-interrupt write from the core retires the highest in-service vector. If that vector was accepted as level-triggered, the unit pulses a notification carrying the vector so that the line can be re-sampled upstream.

Top module: `irq_accept_unit`

## Requirements
- R1: After a synchronous reset, all pending, in-service and trigger-mode bits are zero, the task-priority class is 0, and `irq_req`, `ack_valid` and `eoi_out_valid` are low.
- R2: A message (`msg_valid`) sets the pending bit of `msg_vec` even while `core_ie` is low. `irq_req` is registered: it is high in the cycle after an edge at which `core_ie` was high and some vector was deliverable, and low otherwise.
- R3: A pending vector is deliverable only if its class `vec[7:4]` is strictly greater than the task-priority class and strictly greater than the class of the highest-numbered in-service vector. The in-service class counts as 0 when nothing is in service.
- R4: An `ack` sampled while a vector is deliverable picks the highest-numbered deliverable vector. In the same cycle it clears that vector's pending bit and sets its in-service bit. `ack_valid` pulses with `ack_vec` equal to that vector in the following cycle.
- R5: An `ack` sampled while nothing is deliverable leaves `ack_valid` low and changes no state.
- R6: An `eoi_we` clears the highest-numbered in-service bit. If that vector's trigger-mode bit is 1 (level; `msg_level`=1 means level, 0 means edge), `eoi_out_valid` pulses in the next cycle with `eoi_out_vec` equal to the vector. For an edge vector there is no pulse.
- R7: A message for a vector that is already pending merges into the existing pending bit, so it yields only one acknowledge.
- R8: A `tpr_we` write loads `tpr_wdata` as the new task-priority class. Lowering the class releases pending vectors that it had held back.
- R9: No accepted message is dropped. A pending bit is cleared only by an acknowledge of that vector, so every latched vector is eventually acknowledged once the masking conditions clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Incoming interrupt message strobe |
| msg_vec | input | 8 | Vector carried by the message |
| msg_level | input | 1 | Trigger mode of the message: 1 level, 0 edge |
| core_ie | input | 1 | Interrupt-enable state of the core |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 4 | New task-priority class |
| ack | input | 1 | Core acknowledge |
| eoi_we | input | 1 | End-of-interrupt write from the core |
| irq_req | output | 1 | Registered interrupt request to the core |
| ack_valid | output | 1 | Pulse: an acknowledge was granted |
| ack_vec | output | 8 | Vector returned for the acknowledge |
| eoi_out_valid | output | 1 | Pulse: a level vector was retired |
| eoi_out_vec | output | 8 | Vector of the retired level interrupt |

## Verification
The bench targets several corner cases, and each fault shows up as a concrete misbehaviour.
- Messages that arrive while `core_ie` is low must be latched. A unit that ignored them would never raise `irq_req` after re-enable.
- Vectors sitting exactly at the task-priority class, or at the in-service class, must be held back. An off-by-one comparison would release them early and return the wrong `ack_vec`.
- Duplicate messages must merge. A unit that counted them would acknowledge the same vector twice.
- The trigger mode must be tracked per vector. A mistake there would pulse `eoi_out_valid` for edge vectors, or stay silent for level ones.
- A final drain under random traffic compares the number of granted acknowledges with the number of latched vectors. Any dropped or duplicated message changes that count.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int DEF_VEC_W = 8;
  localparam int DEF_CLS_W = 4;

  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/irqa_top_find.sv
// Finds the highest-numbered set bit of a vector.
module irqa_top_find #(
  parameter int N  = 256,
  parameter int IW = 8
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqa_gate.sv
// Per-vector deliverability: pending and class above both thresholds.
module irqa_gate #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4,
  localparam int N     = 1 << VEC_W,
  localparam int SHIFT = VEC_W - CLS_W
) (
  input  logic [N-1:0]     pend,
  input  logic [CLS_W-1:0] tpr_cls,
  input  logic [CLS_W-1:0] isv_cls,
  output logic [N-1:0]     dlv
);
  for (genvar v = 0; v < N; v++) begin : g_vec
    localparam logic [CLS_W-1:0] VCLS = CLS_W'(v >> SHIFT);
    assign dlv[v] = pend[v] && (VCLS > tpr_cls) && (VCLS > isv_cls);
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irqa_pkg::*;
#(
  parameter int VEC_W = DEF_VEC_W,
  parameter int CLS_W = DEF_CLS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_valid,
  input  logic [VEC_W-1:0] msg_vec,
  input  logic             msg_level,
  input  logic             core_ie,
  input  logic             tpr_we,
  input  logic [CLS_W-1:0] tpr_wdata,
  input  logic             ack,
  input  logic             eoi_we,
  output logic             irq_req,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vec,
  output logic             eoi_out_valid,
  output logic [VEC_W-1:0] eoi_out_vec
);
  localparam int N = 1 << VEC_W;

  logic [N-1:0]     pend, insvc, tmode;
  logic [N-1:0]     pend_n, insvc_n, tmode_n;
  logic [CLS_W-1:0] tpr;
  logic [N-1:0]     dlv;
  logic             isv_any, dlv_any;
  logic [VEC_W-1:0] isv_idx, best;
  logic [CLS_W-1:0] isv_cls;
  logic             do_ack, do_eoi;

  irqa_top_find #(.N(N), .IW(VEC_W)) u_isv_find (
    .bits(insvc), .any(isv_any), .idx(isv_idx)
  );

  assign isv_cls = isv_any ? isv_idx[VEC_W-1 -: CLS_W] : '0;

  irqa_gate #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_gate (
    .pend(pend), .tpr_cls(tpr), .isv_cls(isv_cls), .dlv(dlv)
  );

  irqa_top_find #(.N(N), .IW(VEC_W)) u_dlv_find (
    .bits(dlv), .any(dlv_any), .idx(best)
  );

  assign do_ack = ack && dlv_any;
  assign do_eoi = eoi_we && isv_any;

  always_comb begin
    pend_n  = pend;
    insvc_n = insvc;
    tmode_n = tmode;
    if (do_ack) begin
      pend_n[best]  = 1'b0;
      insvc_n[best] = 1'b1;
    end
    if (do_eoi) insvc_n[isv_idx] = 1'b0;
    if (msg_valid) begin
      pend_n[msg_vec]  = 1'b1;
      tmode_n[msg_vec] = msg_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend          <= '0;
      insvc         <= '0;
      tmode         <= '0;
      tpr           <= '0;
      irq_req       <= 1'b0;
      ack_valid     <= 1'b0;
      ack_vec       <= '0;
      eoi_out_valid <= 1'b0;
      eoi_out_vec   <= '0;
    end else begin
      pend          <= pend_n;
      insvc         <= insvc_n;
      tmode         <= tmode_n;
      if (tpr_we) tpr <= tpr_wdata;
      irq_req       <= dlv_any && core_ie;
      ack_valid     <= do_ack;
      ack_vec       <= best;
      eoi_out_valid <= do_eoi && (tmode[isv_idx] == TRIG_LEVEL);
      eoi_out_vec   <= isv_idx;
    end
  end

  // R2
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(core_ie));

  // R3
  ack_above_tpr_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ack_vec[VEC_W-1 -: CLS_W] > $past(tpr)));

  // R4
  ack_sets_insvc_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> insvc[ack_vec]);

  // R6
  eoi_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_out_valid |-> ($past(eoi_we) && !insvc[eoi_out_vec]));

  // R9
  no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ack) |-> ($countones(pend) >= $countones($past(pend))));
endmodule

// File: tb/irq_accept_unit_bench.sv
module irq_accept_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       msg_valid = 1'b0;
  logic [7:0] msg_vec = '0;
  logic       msg_level = 1'b0;
  logic       core_ie = 1'b0;
  logic       tpr_we = 1'b0;
  logic [3:0] tpr_wdata = '0;
  logic       ack = 1'b0;
  logic       eoi_we = 1'b0;
  logic       irq_req, ack_valid, eoi_out_valid;
  logic [7:0] ack_vec, eoi_out_vec;

  irq_accept_unit u_irq_accept_unit (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_vec(msg_vec),
    .msg_level(msg_level), .core_ie(core_ie), .tpr_we(tpr_we),
    .tpr_wdata(tpr_wdata), .ack(ack), .eoi_we(eoi_we), .irq_req(irq_req),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi_out_valid(eoi_out_valid),
    .eoi_out_vec(eoi_out_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int latched = 0;
  int dut_acks = 0;
  bit finished = 1'b0;

  // behavioural reference model
  bit m_pend [256];
  bit m_isv  [256];
  bit m_tm   [256];
  int m_tpr = 0;
  bit e_irq = 0, e_ackv = 0, e_eoiv = 0;
  int e_ackvec = 0, e_eoivec = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_busy();
    for (int v = 0; v < 256; v++) if (m_pend[v] || m_isv[v]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < 256; v++) begin m_pend[v] = 0; m_isv[v] = 0; m_tm[v] = 0; end
      m_tpr = 0; e_irq = 0; e_ackv = 0; e_eoiv = 0;
    end else begin
      int hi_isv, icls, best;
      hi_isv = -1;
      for (int v = 255; v >= 0; v--) if (m_isv[v]) begin hi_isv = v; break; end
      icls = (hi_isv < 0) ? 0 : hi_isv / 16;
      best = -1;
      for (int v = 255; v >= 0; v--)
        if (m_pend[v] && (v / 16) > m_tpr && (v / 16) > icls) begin best = v; break; end
      e_irq = (best >= 0) && core_ie;
      e_ackv = 0;
      if (ack && best >= 0) begin
        e_ackv = 1; e_ackvec = best; m_pend[best] = 0; m_isv[best] = 1;
      end
      e_eoiv = 0;
      if (eoi_we && hi_isv >= 0) begin
        m_isv[hi_isv] = 0;
        if (m_tm[hi_isv]) begin e_eoiv = 1; e_eoivec = hi_isv; end
      end
      if (msg_valid) begin
        if (!m_pend[msg_vec]) latched++;
        m_pend[msg_vec] = 1; m_tm[msg_vec] = msg_level;
      end
      if (tpr_we) m_tpr = tpr_wdata;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(irq_req == e_irq, "R2 irq_req", irq_req, e_irq);
      chk(ack_valid == e_ackv, "R4 ack_valid", ack_valid, e_ackv);
      if (e_ackv) chk(ack_vec == 8'(e_ackvec), "R4 ack_vec", ack_vec, e_ackvec);
      chk(eoi_out_valid == e_eoiv, "R6 eoi_out_valid", eoi_out_valid, e_eoiv);
      if (e_eoiv) chk(eoi_out_vec == 8'(e_eoivec), "R6 eoi_out_vec", eoi_out_vec, e_eoivec);
      if (ack_valid) dut_acks++;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    msg_valid = 0; ack = 0; eoi_we = 0; tpr_we = 0;
  endtask

  task automatic send(input logic [7:0] v, input logic lvl);
    msg_valid = 1; msg_vec = v; msg_level = lvl;
    step();
  endtask

  task automatic do_ack_chk(input bit exp_valid, input int exp_vec, input string req);
    ack = 1;
    step();
    chk(ack_valid == exp_valid, req, ack_valid, exp_valid);
    if (exp_valid) chk(ack_vec == 8'(exp_vec), req, ack_vec, exp_vec);
  endtask

  task automatic do_eoi_chk(input bit exp_pulse, input int exp_vec, input string req);
    eoi_we = 1;
    step();
    chk(eoi_out_valid == exp_pulse, req, eoi_out_valid, exp_pulse);
    if (exp_pulse) chk(eoi_out_vec == 8'(exp_vec), req, eoi_out_vec, exp_vec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(irq_req == 0, "R1 irq_req after reset", irq_req, 0);
    chk(ack_valid == 0, "R1 ack_valid after reset", ack_valid, 0);
    chk(eoi_out_valid == 0, "R1 eoi_out_valid after reset", eoi_out_valid, 0);

    // R2: latch while disabled
    send(8'h52, 1);
    step();
    chk(irq_req == 0, "R2 held while core_ie low", irq_req, 0);
    core_ie = 1;
    step();
    chk(irq_req == 1, "R2 request after re-enable", irq_req, 1);
    do_ack_chk(1, 8'h52, "R4 first ack");

    // R3: lower class held by in-service 0x52
    send(8'h31, 0);
    step();
    chk(irq_req == 0, "R3 below in-service class", irq_req, 0);
    send(8'h73, 0);
    send(8'h7A, 1);
    do_ack_chk(1, 8'h7A, "R4 highest-numbered");
    do_eoi_chk(1, 8'h7A, "R6 level pulse");
    do_ack_chk(1, 8'h73, "R4 next vector");
    do_eoi_chk(0, 0, "R6 edge no pulse");
    do_eoi_chk(1, 8'h52, "R6 level pulse after edge");
    step();
    chk(irq_req == 1, "R3 released after EOI", irq_req, 1);

    // R5 / R8
    tpr_we = 1; tpr_wdata = 4'd3;
    step();
    do_ack_chk(0, 0, "R5 ack with class equal to threshold");
    step();
    chk(irq_req == 0, "R5 state unchanged after empty ack", irq_req, 0);
    tpr_we = 1; tpr_wdata = 4'd2;
    step();
    step();
    chk(irq_req == 1, "R8 lower threshold releases", irq_req, 1);
    do_ack_chk(1, 8'h31, "R8 ack after threshold drop");
    do_eoi_chk(0, 0, "R6 edge retire");

    // R7: merge
    send(8'h90, 0);
    send(8'h90, 0);
    do_ack_chk(1, 8'h90, "R7 merged ack");
    do_ack_chk(0, 0, "R7 no second ack");
    do_eoi_chk(0, 0, "R7 retire");

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      msg_valid = ($urandom_range(0, 2) == 0);
      msg_vec   = 8'($urandom_range(16, 255));
      msg_level = 1'($urandom_range(0, 1));
      core_ie   = 1'($urandom_range(0, 3) != 0);
      ack       = ($urandom_range(0, 3) == 0);
      eoi_we    = ($urandom_range(0, 4) == 0);
      tpr_we    = ($urandom_range(0, 30) == 0);
      tpr_wdata = 4'($urandom_range(0, 15));
      @(posedge clk);
      @(negedge clk);
    end
    msg_valid = 0; ack = 0; eoi_we = 0;
    tpr_we = 1; tpr_wdata = 0; core_ie = 1;
    step();

    // R9: drain
    for (int c = 0; c < 3000 && model_busy(); c++) begin
      ack = 1; eoi_we = 1;
      @(posedge clk);
      @(negedge clk);
    end
    ack = 0; eoi_we = 0;
    step();
    step();
    chk(dut_acks == latched, "R9 acks equal latched vectors", dut_acks, latched);
    chk(irq_req == 0, "R9 nothing left after drain", irq_req, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule